// File: doc/BRIEF.md
# Keyed Bit-Mixing Core

This block is the nonlinear heart of a bit-serial keyed hash engine. Each accepted cycle takes one data bit and two key bits from an external pseudo-random source. It returns one mixed output bit and advances a small internal state. That state is three flag bits (a phase flag, a history flag and a stored key bit), a four-bit selector, and a ten-entry table that always holds a permutation of 0..9.

The selector leaves the block as `genSel`. The surrounding engine uses it to choose which of its ten key-bit generators to step for the next bit. A fixed boolean map over the three flags, the data bit and the key bits gives the next flags. When the new phase flag is clear, the map also names one table slot. The selector is reloaded from that slot, and in the same clock the table is rearranged by one of twenty fixed cycle patterns, picked by the old selector and the new history flag. Cycles with `valid` low leave everything untouched.

Top module: `bitmix_core`

## Requirements
- R1: After reset the phase flag, history flag and stored key bit are 0, the selector is 0 and table entry i holds i, so `genSel` reads 0.
- R2: `genSel` always shows the current selector value, and that value stays within 0..9.
- R3: `eOut` equals `msgBit` XOR `k1` XOR `k2` in every cycle where `valid` is high.
- R4: A cycle with `valid` low changes no state: later outputs are as if that cycle had not occurred.
- R5: Next phase flag: if the phase flag is 1 it becomes 0; if it is 0 it becomes 1 exactly when `msgBit` equals the history flag.
- R6: On each accepted bit the history flag takes `msgBit` and the stored key bit takes `k2`.
- R7: When the next phase flag is 1, the selector and the table keep their values.
- R8: When the next phase flag is 0, the selector is loaded from the pre-update table slot j. j is 0 when the phase flag was 0. When it was 1, j is chosen by (msgBit, stored key bit, history flag): 000→3, 001→1, 010→4, 011→2, 100→1, 101→3, 110→2, 111→4.
- R9: When the next phase flag is 0, the table is rearranged in one clock, with new entry i taken from old entry src(p,i). Pattern p = 2·(old selector) + msgBit. The twenty src rows, written as the digits for i = 9 down to 0, are fixed constants; p=0 is 1604239785, p=1 is 4509186732 and p=6 is 2561037984.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Accept the present bit this cycle |
| msgBit | input | 1 | Data bit to mix |
| k1 | input | 1 | First key bit from the selected generator |
| k2 | input | 1 | Second key bit from the selected generator |
| eOut | output | 1 | Mixed output bit (combinational, meaningful while valid) |
| genSel | output | 4 | Current selector, the generator to step next |

## Verification
The assertions assume that `valid`, `msgBit`, `k1` and `k2` are known (0 or 1) at every rising edge after reset. They also assume the inputs change only between edges, so the value seen at an edge is the one the core consumed. The bench drives every input from a falling edge and holds it through the next rising edge, and it sets all four to 0 before releasing reset. Its long pseudo-random run lowers `valid` at random while the data inputs keep toggling. This exercises the hold assumptions without driving an undefined value.

// File: rtl/bitmix_pkg.sv
package bitmix_pkg;

  localparam int NUM_ENTRIES = 10;
  localparam int IDX_W       = 4;
  localparam int SLOT_W      = 3;
  localparam int PAT_W       = IDX_W + 1;
  localparam int ROW_W       = NUM_ENTRIES * IDX_W;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic              upd;
    logic [SLOT_W-1:0] slot;
    logic              sNew;
  } ctlStrobe_t;

  function automatic logic [ROW_W-1:0] identityRow();
    logic [ROW_W-1:0] r;
    for (int i = 0; i < NUM_ENTRIES; i++) r[i*IDX_W +: IDX_W] = IDX_W'(i);
    return r;
  endfunction

  // Source-index rows: nibble i gives the old entry moved into entry i.
  function automatic logic [ROW_W-1:0] permRow(input logic [PAT_W-1:0] pat);
    case (pat)
      5'd0:  permRow = 40'h1604239785;
      5'd1:  permRow = 40'h4509186732;
      5'd2:  permRow = 40'h5918732406;
      5'd3:  permRow = 40'h1790324856;
      5'd4:  permRow = 40'h4795186023;
      5'd5:  permRow = 40'h0437851926;
      5'd6:  permRow = 40'h2561037984;
      5'd7:  permRow = 40'h8612407395;
      5'd8:  permRow = 40'h5947362108;
      5'd9:  permRow = 40'h7180325649;
      5'd10: permRow = 40'h0325918467;
      5'd11: permRow = 40'h6359270841;
      5'd12: permRow = 40'h2163890547;
      5'd13: permRow = 40'h7148265093;
      5'd14: permRow = 40'h3465720198;
      5'd15: permRow = 40'h6283071459;
      5'd16: permRow = 40'h8021459637;
      5'd17: permRow = 40'h3082615974;
      5'd18: permRow = 40'h1054698372;
      5'd19: permRow = 40'h8237904561;
      default: permRow = identityRow();
    endcase
  endfunction

endpackage

// File: rtl/bitmix_ctrl.sv
module bitmix_ctrl
  import bitmix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       valid,
  input  logic       msgBit,
  input  logic       k1,
  input  logic       k2,
  output logic       eOut,
  output logic       rBit,
  output logic       sBit,
  output ctlStrobe_t stb
);

  logic sQ, rQ, d0Q;
  logic rNew;
  logic [SLOT_W-1:0] slotSel;

  // Boolean map: flags and data bit select the next phase flag and the slot.
  always_comb begin
    rNew    = 1'b0;
    slotSel = '0;
    case ({msgBit, d0Q, rQ, sQ})
      4'b0000, 4'b0100: begin rNew = 1'b1; slotSel = 3'd0; end
      4'b0001, 4'b0101: begin rNew = 1'b0; slotSel = 3'd0; end
      4'b1000, 4'b1100: begin rNew = 1'b0; slotSel = 3'd0; end
      4'b1001, 4'b1101: begin rNew = 1'b1; slotSel = 3'd0; end
      4'b0010:          begin rNew = 1'b0; slotSel = 3'd3; end
      4'b0011:          begin rNew = 1'b0; slotSel = 3'd1; end
      4'b0110:          begin rNew = 1'b0; slotSel = 3'd4; end
      4'b0111:          begin rNew = 1'b0; slotSel = 3'd2; end
      4'b1010:          begin rNew = 1'b0; slotSel = 3'd1; end
      4'b1011:          begin rNew = 1'b0; slotSel = 3'd3; end
      4'b1110:          begin rNew = 1'b0; slotSel = 3'd2; end
      4'b1111:          begin rNew = 1'b0; slotSel = 3'd4; end
      default:          begin rNew = 1'b0; slotSel = 3'd0; end
    endcase
  end

  assign eOut = msgBit ^ k1 ^ k2;

  always_comb begin
    stb.upd  = valid & ~rNew;
    stb.slot = slotSel;
    stb.sNew = msgBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sQ  <= 1'b0;
      rQ  <= 1'b0;
      d0Q <= 1'b0;
    end else if (valid) begin
      sQ  <= msgBit;
      rQ  <= rNew;
      d0Q <= k2;
    end
  end

  assign rBit = rQ;
  assign sBit = sQ;

endmodule

// File: rtl/bitmix_dpath.sv
module bitmix_dpath
  import bitmix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  output idx_t       dSel
);

  idx_t dQ;
  idx_t tQ    [NUM_ENTRIES];
  idx_t nextT [NUM_ENTRIES];
  logic [ROW_W-1:0] srcRow;

  assign srcRow = permRow({dQ, stb.sNew});

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      nextT[i] = tQ[srcRow[i*IDX_W +: IDX_W]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dQ <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) tQ[i] <= IDX_W'(i);
    end else if (stb.upd) begin
      dQ <= tQ[{1'b0, stb.slot}];
      for (int i = 0; i < NUM_ENTRIES; i++) tQ[i] <= nextT[i];
    end
  end

  assign dSel = dQ;

endmodule

// File: rtl/bitmix_core.sv
module bitmix_core
  import bitmix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       valid,
  input  logic       msgBit,
  input  logic       k1,
  input  logic       k2,
  output logic       eOut,
  output logic [3:0] genSel
);

  ctlStrobe_t stb;
  logic rBit, sBit;
  idx_t dSel;

  bitmix_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .valid(valid), .msgBit(msgBit),
    .k1(k1), .k2(k2), .eOut(eOut), .rBit(rBit), .sBit(sBit), .stb(stb)
  );

  bitmix_dpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dSel(dSel)
  );

  assign genSel = dSel;

endmodule

// File: rtl/bitmix_core_chk.sv
module bitmix_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic       valid,
  input logic       msgBit,
  input logic [3:0] genSel,
  input logic       rBit,
  input logic       sBit
);

  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    genSel < 4'd10);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> ($stable(genSel) && $stable(rBit) && $stable(sBit)));

  // R5
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && rBit) |=> !rBit);

  // R5
  phase_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !rBit && (msgBit == sBit)) |=> rBit);

  // R6
  history_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> (sBit == $past(msgBit)));

  // R7
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !rBit && (msgBit == sBit)) |=> $stable(genSel));

endmodule

bind bitmix_core bitmix_core_chk uChk (
  .clk(clk), .rstN(rstN), .valid(valid), .msgBit(msgBit),
  .genSel(genSel), .rBit(rBit), .sBit(sBit)
);

// File: tb/bitmix_core_test.sv
module bitmix_core_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic valid = 1'b0, msgBit = 1'b0, k1 = 1'b0, k2 = 1'b0;
  logic eOut;
  logic [3:0] genSel;

  int checks = 0;
  int errors = 0;

  // reference state
  int mS, mR, mD0, mD;
  int mT [10];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  bitmix_core uut (
    .clk(clk), .rstN(rstN), .valid(valid), .msgBit(msgBit),
    .k1(k1), .k2(k2), .eOut(eOut), .genSel(genSel)
  );

  always #5 clk = ~clk;

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [39:0] refRow(input int p);
    case (p)
      0: return 40'h1604239785;   1: return 40'h4509186732;
      2: return 40'h5918732406;   3: return 40'h1790324856;
      4: return 40'h4795186023;   5: return 40'h0437851926;
      6: return 40'h2561037984;   7: return 40'h8612407395;
      8: return 40'h5947362108;   9: return 40'h7180325649;
      10: return 40'h0325918467;  11: return 40'h6359270841;
      12: return 40'h2163890547;  13: return 40'h7148265093;
      14: return 40'h3465720198;  15: return 40'h6283071459;
      16: return 40'h8021459637;  17: return 40'h3082615974;
      18: return 40'h1054698372;  default: return 40'h8237904561;
    endcase
  endfunction

  function automatic int refSlot(input int m, input int d0, input int s);
    int lut [8] = '{3, 1, 4, 2, 1, 3, 2, 4};
    return lut[m*4 + d0*2 + s];
  endfunction

  task automatic modelReset();
    mS = 0; mR = 0; mD0 = 0; mD = 0;
    for (int i = 0; i < 10; i++) mT[i] = i;
  endtask

  task automatic modelStep(input int m, input int kb2);
    int nr, slot, old [10];
    logic [39:0] row;
    nr = (mR == 1) ? 0 : ((m == mS) ? 1 : 0);
    if (nr == 0) begin
      slot = (mR == 1) ? refSlot(m, mD0, mS) : 0;
      row = refRow(2*mD + m);
      for (int i = 0; i < 10; i++) old[i] = mT[i];
      for (int i = 0; i < 10; i++) mT[i] = old[row[i*4 +: 4]];
      mD = old[slot];
    end
    mR = nr; mS = m; mD0 = kb2;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; valid = 1'b0; msgBit = 1'b0; k1 = 1'b0; k2 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  // One accepted or idle cycle; checks e before the edge and genSel after it.
  task automatic step(input logic v, input logic m, input logic a, input logic b,
                      input string req);
    @(negedge clk);
    valid = v; msgBit = m; k1 = a; k2 = b;
    #2;
    if (v) check("R3 eOut", int'(eOut), int'(m ^ a ^ b));
    @(posedge clk);
    #1;
    if (v) modelStep(int'(m), int'(b));
    check(req, int'(genSel), mD);
  endtask

  task automatic testReset();
    doReset();
    #1 check("R1 genSel after reset", int'(genSel), 0);
  endtask

  task automatic testOutputBit();
    doReset();
    for (int c = 0; c < 8; c++) step(1'b1, c[0], c[1], c[2], "R3 trace");
  endtask

  task automatic testHold();
    doReset();
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7 hold on phase set");
    check("R7 genSel unchanged", int'(genSel), 0);
  endtask

  task automatic testLoadSlot();
    doReset();
    step(1'b1, 1'b0, 1'b0, 1'b0, "R7 first bit");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R8 load");
    check("R8 slot 3 after 000", int'(genSel), 3);
    doReset();
    step(1'b1, 1'b0, 1'b0, 1'b1, "R6 first bit");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R6 load");
    check("R6 stored k2 selects slot 4", int'(genSel), 4);
  endtask

  task automatic testPermute();
    doReset();
    step(1'b1, 1'b1, 1'b0, 1'b0, "R9 first bit");
    check("R9 selector from slot 0", int'(genSel), 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, "R9 second bit");
    check("R9 pattern 1 moved entry 2 to slot 0", int'(genSel), 2);
  endtask

  task automatic testIdle();
    doReset();
    step(1'b1, 1'b0, 1'b0, 1'b0, "R4 prime");
    for (int i = 0; i < 5; i++) step(1'b0, i[0], 1'b1, ~i[0], "R4 idle");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R4 resume");
    check("R4 idle cycles ignored", int'(genSel), 3);
  endtask

  task automatic testRandom();
    doReset();
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[7:5] != 3'b000, lfsr[2], lfsr[9], lfsr[13], "R5 R8 R9 random trace");
      check("R2 selector range", int'(genSel < 4'd10), 1);
    end
  endtask

  initial begin
    modelReset();
    testReset();
    testOutputBit();
    testHold();
    testLoadSlot();
    testPermute();
    testIdle();
    testRandom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule